// File: doc/BRIEF.md
# SPI serial clock generator with programmable duty

This block derives the serial clock of an SPI master from an 80 MHz base clock by whole-number division. The period is `n` base cycles. The time the clock spends at its active (non-idle) level is set in steps of 1/2^DUTY_W of the period. One of the four usual polarity/phase modes fixes the idle level and which edge of the period launches data and which one samples it. Beside the clock it emits two strobes, each one base cycle long, that tell a neighbouring shift engine when to drive a new bit and when to capture the incoming one. At eight periods per byte, the engine counts strobes to frame its bytes.

A run input starts and stops the clock. A stop is honoured only at the end of the period in progress, so no shortened pulse ever reaches the pin. Divisor and duty are taken at every period boundary. The mode is taken only while the block is stopped. A divisor of one passes the base clock straight through and ignores duty.

A small combinational helper, independent of the clock path, turns a requested rate in kHz into the divisor whose 80 MHz/n rate lies closest to it. Software or a wrapper can load that value into the divisor input.

Top module: `sclk_gen`

## Requirements
- R1: For a divisor n of 2 or more, each serial clock period lasts exactly n base cycles. A divisor input of 0 behaves exactly like 1.
- R2: The active-level time of a period is round(n*d/2^DUTY_W) base cycles, clamped to 1..n-1, where d is the duty input and a duty of 0 counts as 2^(DUTY_W-1), half the period.
- R3: Mode bit 1 is the idle level of the serial clock. With mode bit 0 clear, the sample strobe marks the leading edge (idle to active) and the launch strobe marks the trailing edge. With mode bit 0 set, the two are swapped.
- R4: In divided operation each strobe is high for one base cycle, in the same cycle in which the serial clock makes the matching edge. The first leading edge appears in the cycle after the base-clock edge that first sees run high.
- R5: With a divisor of 1, the serial clock is the base clock, starting one cycle after the base-clock edge that sees run high. It is at the active level in the first half of each base cycle. Both strobes are high in every such cycle, and the duty input has no effect.
- R6: When run is low at the end of a period, the clock finishes that period and then rests at its idle level with both strobes low. At a divisor of 1, exactly one more base-clock pulse follows the edge that sees run low.
- R7: A change of divisor or duty during a period takes effect at the start of the next period.
- R8: The mode input is taken only while run is low and the clock is stopped. Changing it while the clock runs leaves level and strobes unchanged.
- R9: The rate helper returns the divisor n in 1..2^DIV_W-1 that minimises |80000/n - req| for a requested rate req in kHz. A tie goes to the smaller n, and a request of 0 gives the largest divisor.
- R10: During reset the serial clock is low and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 80 MHz base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Run (1) or stop at end of period (0) |
| div_i | input | DIV_W | Divisor n; 0 acts as 1 |
| duty_i | input | DUTY_W | Active-level time in 1/2^DUTY_W of the period; 0 means half |
| mode_i | input | 2 | Bit 1: idle level; bit 0: phase (launch on leading edge when set) |
| req_khz_i | input | FREQ_W | Requested rate for the divisor helper, in kHz |
| div_sugg_o | output | DIV_W | Divisor whose rate is nearest the request |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe: drive next data bit |
| sample_o | output | 1 | One-cycle strobe: capture incoming bit |

## Verification
The hardest situation to reach from the ports is a change of settings in the middle of a running period. To get there, the stimulus starts each run with one divisor and duty, loads a different pair one cycle later, and inverts the mode for the rest of the run. The expected waveform keeps the first pair for the whole first period, switches to the second pair from the next boundary, and follows the original mode throughout. Run is dropped just after the third period begins, so the stop must wait out a full period of the new length. Every divisor of a 5-bit configuration is swept under several duties, including values that round to zero or to the full period, across all four modes. The divisor helper is swept against an exact integer nearest-rate search, including an exact tie.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

   typedef struct packed {
      logic idle_hi;   // serial clock idle level
      logic late_smp;  // 1: launch on leading edge, sample on trailing
   } spi_mode_t;

   // Returns {launch, sample} for the divided path.
   function automatic logic [1:0] route_strobes(input logic late_smp,
                                                input logic lead,
                                                input logic trail);
      logic launch;
      logic sample;
      launch = late_smp ? lead  : trail;
      sample = late_smp ? trail : lead;
      return {launch, sample};
   endfunction

endpackage

// File: rtl/sclk_rate_pick.sv
module sclk_rate_pick #(
   parameter int DIV_W    = 8,
   parameter int FREQ_W   = 17,
   parameter int BASE_KHZ = 80000
) (
   input  logic [FREQ_W-1:0] req_khz_i,
   output logic [DIV_W-1:0]  div_o
);
   localparam int          DIV_MAX = (1 << DIV_W) - 1;
   localparam logic [63:0] BASE64  = 64'(BASE_KHZ);
   localparam logic [63:0] MAX64   = 64'(DIV_MAX);

   logic [63:0] req64;
   logic [63:0] n_lo;
   logic [63:0] lhs;
   logic [63:0] rhs;

   assign req64 = 64'(req_khz_i);

   always_comb begin
      n_lo = '0;
      lhs  = '0;
      rhs  = '0;
      if (req64 == 64'd0) begin
         div_o = DIV_W'(DIV_MAX);
      end else begin
         n_lo = BASE64 / req64;
         if (n_lo == 64'd0) begin
            div_o = DIV_W'(1);
         end else if (n_lo >= MAX64) begin
            div_o = DIV_W'(DIV_MAX);
         end else begin
            // faster neighbour BASE/n_lo >= req > BASE/(n_lo+1)
            lhs = BASE64 * (2 * n_lo + 64'd1);
            rhs = 64'd2 * req64 * n_lo * (n_lo + 64'd1);
            div_o = (lhs > rhs) ? DIV_W'(n_lo + 64'd1) : DIV_W'(n_lo);
         end
      end
   end

   // R9
   always_comb begin
      div_range_chk: assert (div_o >= DIV_W'(1) && div_o <= DIV_W'(DIV_MAX));
   end

endmodule

// File: rtl/sclk_div_core.sv
module sclk_div_core #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [DIV_W-1:0] n_i,
   input  logic [DIV_W-1:0] h_i,
   output logic             busy_o,
   output logic             act_o,
   output logic             lead_o,
   output logic             trail_o
);
   logic             busy_q;
   logic             act_q;
   logic             lead_q;
   logic             trail_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] n_q;
   logic [DIV_W-1:0] h_q;
   logic [DIV_W-1:0] cnt_nx;
   logic             period_end;

   assign cnt_nx     = cnt_q + 1'b1;
   assign period_end = !busy_q || (cnt_q == n_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         act_q   <= 1'b0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
         cnt_q   <= '0;
         n_q     <= DIV_W'(2);
         h_q     <= DIV_W'(1);
      end else begin
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
         if (period_end) begin
            cnt_q <= '0;
            if (go_i) begin
               busy_q <= 1'b1;
               n_q    <= n_i;
               h_q    <= h_i;
               act_q  <= 1'b1;
               lead_q <= 1'b1;
            end else begin
               busy_q <= 1'b0;
               act_q  <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_nx;
            if (cnt_nx == h_q) begin
               act_q   <= 1'b0;
               trail_q <= 1'b1;
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign act_o   = act_q;
   assign lead_o  = lead_q;
   assign trail_o = trail_q;

   // length of the active phase just ended, for the duty check
   logic [DIV_W-1:0] hi_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_len_q <= '0;
      else if (act_q) hi_len_q <= hi_len_q + 1'b1;
      else            hi_len_q <= '0;
   end

   // R2
   hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_q) |-> (hi_len_q == h_q));

   // R4
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_q && trail_q));

endmodule

// File: rtl/sclk_bypass_gate.sv
module sclk_bypass_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic gate_o,
   output logic en_lo_o,
   output logic strobe_o
);
   logic gate_q;
   logic en_lo_q;
   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_q   <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         gate_q   <= req_i;
         strobe_q <= gate_q;
      end
   end

   // enable moves only while the base clock is low: no clipped pulse
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_lo_q <= 1'b0;
      else        en_lo_q <= gate_q;
   end

   assign gate_o   = gate_q;
   assign en_lo_o  = en_lo_q;
   assign strobe_o = strobe_q;

   // R5
   gate_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_lo_q == gate_q);

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
   import sclk_gen_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int DUTY_W   = 8,
   parameter int FREQ_W   = 17,
   parameter int BASE_KHZ = 80000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [DUTY_W-1:0] duty_i,
   input  logic [1:0]        mode_i,
   input  logic [FREQ_W-1:0] req_khz_i,
   output logic [DIV_W-1:0]  div_sugg_o,
   output logic              sclk_o,
   output logic              launch_o,
   output logic              sample_o
);
   localparam int PW   = DIV_W + DUTY_W + 1;
   localparam int HALF = 1 << (DUTY_W - 1);

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("sclk_gen: DIV_W must be at least 2");
      end
      if (DUTY_W < 2) begin : g_bad_duty
         $error("sclk_gen: DUTY_W must be at least 2");
      end
      if (FREQ_W > 24 || BASE_KHZ >= (1 << FREQ_W) || BASE_KHZ < 1) begin : g_bad_freq
         $error("sclk_gen: BASE_KHZ must be positive and fit FREQ_W (<= 24)");
      end
   endgenerate

   // effective divisor, duty and active-phase length
   logic [DIV_W-1:0]  n_eff;
   logic [DUTY_W-1:0] d_eff;
   logic [PW-1:0]     prod;
   logic [DIV_W:0]    h_raw;
   logic [DIV_W-1:0]  h_eff;

   assign n_eff = (div_i == '0) ? DIV_W'(1) : div_i;
   assign d_eff = (duty_i == '0) ? DUTY_W'(HALF) : duty_i;
   assign prod  = PW'(n_eff) * PW'(d_eff) + PW'(HALF);
   assign h_raw = prod[PW-1:DUTY_W];

   always_comb begin
      if (h_raw == '0)                    h_eff = DIV_W'(1);
      else if (h_raw >= {1'b0, n_eff})    h_eff = n_eff - 1'b1;
      else                                h_eff = h_raw[DIV_W-1:0];
   end

   // path selection
   logic core_busy;
   logic core_act;
   logic core_lead;
   logic core_trail;
   logic gate_on;
   logic gate_en_lo;
   logic gate_stb;
   logic core_go;
   logic byp_req;

   assign core_go = run && (n_eff >= DIV_W'(2)) && !gate_on && !gate_en_lo;
   assign byp_req = run && (n_eff == DIV_W'(1)) && !core_busy;

   sclk_div_core #(.DIV_W(DIV_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (core_go),
      .n_i     (n_eff),
      .h_i     (h_eff),
      .busy_o  (core_busy),
      .act_o   (core_act),
      .lead_o  (core_lead),
      .trail_o (core_trail)
   );

   sclk_bypass_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (byp_req),
      .gate_o   (gate_on),
      .en_lo_o  (gate_en_lo),
      .strobe_o (gate_stb)
   );

   sclk_rate_pick #(
      .DIV_W    (DIV_W),
      .FREQ_W   (FREQ_W),
      .BASE_KHZ (BASE_KHZ)
   ) u_rate (
      .req_khz_i (req_khz_i),
      .div_o     (div_sugg_o)
   );

   // mode register: loaded only while fully stopped and not starting
   spi_mode_t mode_q;
   logic      stopped;

   assign stopped = !core_busy && !gate_on && !gate_en_lo && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (stopped) mode_q <= spi_mode_t'(mode_i);
   end

   logic [1:0] div_stb;
   assign div_stb = route_strobes(mode_q.late_smp, core_lead, core_trail);

   assign sclk_o   = mode_q.idle_hi ^ (gate_en_lo ? clk : core_act);
   assign launch_o = gate_stb | div_stb[1];
   assign sample_o = gate_stb | div_stb[0];

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_busy || gate_en_lo) |-> $stable(mode_q));

endmodule

// File: tb/sim_sclk_gen.sv
module sim_sclk_gen;
   localparam int DW      = 5;
   localparam int UW      = 8;
   localparam int FW      = 17;
   localparam int BASE    = 80000;
   localparam int DMAX    = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          run;
   logic [DW-1:0] div_i;
   logic [UW-1:0] duty_i;
   logic [1:0]    mode_i;
   logic [FW-1:0] req_khz;
   logic [DW-1:0] div_sugg;
   logic          sclk;
   logic          launch;
   logic          sample;

   int vecs  = 0;
   int fails = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   sclk_gen #(.DIV_W(DW), .DUTY_W(UW), .FREQ_W(FW), .BASE_KHZ(BASE)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .div_i      (div_i),
      .duty_i     (duty_i),
      .mode_i     (mode_i),
      .req_khz_i  (req_khz),
      .div_sugg_o (div_sugg),
      .sclk_o     (sclk),
      .launch_o   (launch),
      .sample_o   (sample)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // active-phase length from the rounding rule
   function automatic int exp_high(input int n, input int d);
      int de;
      int h;
      de = (d == 0) ? 128 : d;
      h  = $rtoi($floor(real'(n) * real'(de) / 256.0 + 0.5));
      if (h < 1)     h = 1;
      if (h > n - 1) h = n - 1;
      return h;
   endfunction

   // exact nearest-rate search over all divisors
   function automatic int ref_div(input int r);
      longint best;
      longint dn;
      longint db;
      best = 1;
      for (int n = 2; n <= DMAX; n++) begin
         dn = longint'(BASE) - longint'(r) * n;
         if (dn < 0) dn = -dn;
         db = longint'(BASE) - longint'(r) * best;
         if (db < 0) db = -db;
         if (dn * best < db * n) best = n;
      end
      return int'(best);
   endfunction

   task automatic run_div(input int m, input int n, input int d, input int n2, input int d2);
      int np;
      int hp;
      int cpol;
      int cpha;
      int lead;
      int trail;
      string stag;
      string btag;
      cpol = (m >> 1) & 1;
      cpha = m & 1;
      @(posedge clk); #2;
      run = 0; mode_i = 2'(m); div_i = DW'(n); duty_i = UW'(d);
      repeat (2) @(posedge clk);
      #1 chk("R3", "idle level before start", int'(sclk), cpol);
      #1 run = 1;
      for (int p = 0; p < 3; p++) begin
         np   = (p == 0) ? n : n2;
         hp   = (p == 0) ? exp_high(n, d) : exp_high(n2, d2);
         stag = (p == 0) ? "R2" : ((p == 1) ? "R7" : "R8");
         btag = (p == 0) ? "R3" : "R4";
         for (int pos = 0; pos < np; pos++) begin
            @(posedge clk); #1;
            lead  = (pos == 0)  ? 1 : 0;
            trail = (pos == hp) ? 1 : 0;
            chk(stag, $sformatf("sclk m%0d n%0d pos%0d", m, np, pos), int'(sclk),
                cpol ^ ((pos < hp) ? 1 : 0));
            chk(btag, $sformatf("launch m%0d n%0d pos%0d", m, np, pos), int'(launch),
                cpha ? lead : trail);
            chk(btag, $sformatf("sample m%0d n%0d pos%0d", m, np, pos), int'(sample),
                cpha ? trail : lead);
            #1;
            if (p == 0 && pos == 0) begin
               div_i = DW'(n2); duty_i = UW'(d2); mode_i = 2'(m ^ 3);
            end
            if (p == 2 && pos == 0) begin
               run = 0; mode_i = 2'(m);
            end
         end
      end
      for (int k = 0; k < 2; k++) begin
         @(posedge clk); #1;
         chk("R6", "sclk after stop", int'(sclk), cpol);
         chk("R6", "launch after stop", int'(launch), 0);
         chk("R6", "sample after stop", int'(sample), 0);
      end
   endtask

   task automatic run_byp(input int m, input int dv, input int d);
      int cpol;
      string tag;
      cpol = (m >> 1) & 1;
      tag  = (dv == 0) ? "R1" : "R5";
      @(posedge clk); #2;
      run = 0; mode_i = 2'(m); div_i = DW'(dv); duty_i = UW'(d);
      repeat (2) @(posedge clk);
      #2 run = 1;
      @(posedge clk); #1;
      chk(tag, "sclk before first pulse", int'(sclk), cpol);
      chk(tag, "strobes before first pulse", int'(launch) + int'(sample), 0);
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         chk(tag, $sformatf("pass-through high half m%0d d%0d", m, d), int'(sclk), 1 - cpol);
         chk(tag, "launch each cycle", int'(launch), 1);
         chk(tag, "sample each cycle", int'(sample), 1);
         @(negedge clk); #1;
         chk(tag, "pass-through low half", int'(sclk), cpol);
      end
      run = 0;
      @(posedge clk); #1;
      chk("R6", "final pulse after stop", int'(sclk), 1 - cpol);
      chk("R6", "final strobes", int'(launch) + int'(sample), 2);
      @(negedge clk); #1;
      chk("R6", "final pulse low half", int'(sclk), cpol);
      @(posedge clk); #1;
      chk("R6", "stopped sclk", int'(sclk), cpol);
      chk("R6", "stopped strobes", int'(launch) + int'(sample), 0);
      @(negedge clk); #1;
      chk("R6", "stopped sclk low half", int'(sclk), cpol);
   endtask

   initial begin
      int dl[5];
      dl[0] = 0; dl[1] = 1; dl[2] = 64; dl[3] = 200; dl[4] = 255;
      rst_n = 0; run = 0; div_i = DW'(2); duty_i = '0; mode_i = 2'd2; req_khz = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R10", "sclk in reset", int'(sclk), 0);
      chk("R10", "launch in reset", int'(launch), 0);
      chk("R10", "sample in reset", int'(sample), 0);
      #1 rst_n = 1;

      for (int m = 0; m < 4; m++)
         for (int n = 2; n <= DMAX; n++)
            for (int di = 0; di < 5; di++)
               run_div(m, n, dl[di], 2 + (n * 7) % (DMAX - 1), dl[(di + 2) % 5]);

      for (int m = 0; m < 4; m++) begin
         run_byp(m, 1, 10);
         run_byp(m, 1, 200);
         run_byp(m, 0, 0);
      end

      for (int r = 0; r <= 90000; r += 7) begin
         req_khz = FW'(r);
         #1 chk("R9", $sformatf("divisor for %0d kHz", r), int'(div_sugg), ref_div(r));
      end
      req_khz = FW'(60000);
      #1 chk("R9", "tie 80/40 MHz", int'(div_sugg), 1);
      req_khz = FW'(26667);
      #1 chk("R9", "26.667 MHz", int'(div_sugg), 3);
      req_khz = FW'(1);
      #1 chk("R9", "very slow request", int'(div_sugg), DMAX);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R6 watchdog: run never completed, got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

endmodule